// File: doc/BRIEF.md
# Low-Power Lane Request Decoder

This block watches the two single-ended line levels of a serial data lane while the lane is in low-power signalling. It classifies the request that begins from the idle stop level. It tells apart a high-speed burst request, an escape-mode entry and a bus turnaround. Two of these requests begin with the same steps, so the decision is made only on the final step.

Each input line passes through a synchroniser. A decoded level is accepted only after it has been stable for `DWELL_CYCLES` clocks. A recognised request produces a single-cycle pulse. A step that breaks every legal sequence produces a single-cycle error pulse, and the decoder ignores the lines until they return to the stop level. Two level outputs show whether the lane sits in stop or is inside escape mode. While the lane is inside escape mode, the block detects the exit step back to stop.

Top module: `lp_req_decoder`

## Requirements
- R1: Out of reset all pulse outputs and `stop_o` are low. `stop_o` stays low until the stop level has been accepted, whatever other level the lines hold.
- R2: The line pair is read as {`lane_dp_i`,`lane_dn_i`}, so "level xy" means dp=x and dn=y. The stop level is 11. After 11 has been held for the synchroniser delay plus `DWELL_CYCLES`, `stop_o` goes high.
- R3: From stop, the steps 01 then 00 give exactly one `hs_req_o` pulse and drop `stop_o`. After that, every level other than 11 gives no pulse of any kind. Level 11 brings `stop_o` back.
- R4: From stop, the steps 10, 00, 01, 00 give exactly one `esc_req_o` pulse. `in_esc_o` then rises and `stop_o` stays low.
- R5: From stop, the steps 10, 00, 10, 00 give exactly one `trn_req_o` pulse. `stop_o` then stays low until 11 is accepted again, and that return raises no error.
- R6: Inside escape mode, 10 followed by 11 gives one `esc_exit_o` pulse, clears `in_esc_o` and raises `stop_o`. A 10 that is followed by 00 is payload: it leaves `in_esc_o` high and gives no exit pulse.
- R7: Any accepted step that departs from every legal sequence gives one `seq_err_o` pulse and no request pulse. If that step is 11, the decoder is back in stop at once. Otherwise it waits for 11 before it decodes again.
- R8: A level held for fewer than `DWELL_CYCLES` synchronised cycles is never accepted and causes no pulse.
- R9: Every pulse output is exactly one clock wide, and at most one pulse output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lane_dp_i | input | 1 | Positive line low-power receiver level (asynchronous) |
| lane_dn_i | input | 1 | Negative line low-power receiver level (asynchronous) |
| hs_req_o | output | 1 | One-cycle pulse: high-speed request recognised |
| esc_req_o | output | 1 | One-cycle pulse: escape-mode entry recognised |
| trn_req_o | output | 1 | One-cycle pulse: turnaround request recognised |
| seq_err_o | output | 1 | One-cycle pulse: illegal step |
| esc_exit_o | output | 1 | One-cycle pulse: escape exit to stop |
| stop_o | output | 1 | Lane rests in the stop level and is armed |
| in_esc_o | output | 1 | Lane is inside escape mode |

## Verification
The hardest cases are the partial sequences that share a prefix and then diverge or fall back to 11. They can only be reached by holding each level past the dwell filter in exact order. The bench sweeps every two-step path out of stop and each time returns to 11, so the abandoned escape/turnaround prefix and the stray-11 error path are both exercised. Escape payload that contains a mark-1 tests that 10 alone does not end escape mode. A short hold below the dwell count tests the filter.

// File: rtl/lp_req_pkg.sv
package lp_req_pkg;

   typedef enum logic [1:0] {
      LVL_00 = 2'b00,
      LVL_01 = 2'b01,
      LVL_10 = 2'b10,
      LVL_11 = 2'b11
   } lp_lvl_e;

   typedef enum logic [3:0] {
      SQ_WAIT   = 4'd0,
      SQ_STOP   = 4'd1,
      SQ_HS_A   = 4'd2,
      SQ_HS_RUN = 4'd3,
      SQ_P_A    = 4'd4,
      SQ_P_B    = 4'd5,
      SQ_ESC_C  = 4'd6,
      SQ_TRN_C  = 4'd7,
      SQ_ESC    = 4'd8,
      SQ_ESC_X  = 4'd9
   } seq_st_e;

   typedef struct packed {
      logic hs;
      logic esc;
      logic trn;
      logic err;
      logic esc_exit;
   } req_pulse_t;

endpackage

// File: rtl/lp_line_sync.sv
module lp_line_sync #(
   parameter int STAGES = 2,
   parameter int LINES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINES-1:0] d_i,
   output logic [LINES-1:0] q_o
);

   for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= '0;
         else        chain_q <= {chain_q[STAGES-2:0], d_i[l]};
      end
      assign q_o[l] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/lp_dwell_filter.sv
module lp_dwell_filter #(
   parameter int DWELL = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] sample_i,
   output logic [1:0] level_o,
   output logic       change_o
);

   logic [1:0] conf_q;
   logic       chg_q;

   if (DWELL == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            conf_q <= 2'b00;
            chg_q  <= 1'b0;
         end else begin
            conf_q <= sample_i;
            chg_q  <= (sample_i != conf_q);
         end
      end
   end else begin : g_count
      localparam int CNT_W = $clog2(DWELL + 1);
      localparam logic [CNT_W-1:0] RUN_MAX = CNT_W'(DWELL);

      logic [1:0]       cand_q;
      logic [CNT_W-1:0] run_q;
      logic [CNT_W-1:0] run_d;
      logic             settle;

      always_comb begin
         if (sample_i != cand_q)  run_d = CNT_W'(1);
         else if (run_q != RUN_MAX) run_d = run_q + 1'b1;
         else                      run_d = run_q;
      end

      assign settle = (run_d == RUN_MAX);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cand_q <= 2'b00;
            run_q  <= '0;
            conf_q <= 2'b00;
            chg_q  <= 1'b0;
         end else begin
            cand_q <= sample_i;
            run_q  <= run_d;
            chg_q  <= settle && (sample_i != conf_q);
            if (settle) conf_q <= sample_i;
         end
      end
   end

   assign level_o  = conf_q;
   assign change_o = chg_q;

endmodule

// File: rtl/lp_seq_fsm.sv
module lp_seq_fsm
   import lp_req_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] level_i,
   input  logic       change_i,
   output req_pulse_t pulse_o,
   output logic       stop_o,
   output logic       in_esc_o
);

   seq_st_e    st_q, st_d;
   req_pulse_t pls_q, pls_d;
   lp_lvl_e    lvl;

   assign lvl = lp_lvl_e'(level_i);

   always_comb begin
      st_d  = st_q;
      pls_d = '0;
      if (change_i) begin
         unique case (st_q)
            SQ_WAIT: begin
               if (lvl == LVL_11) st_d = SQ_STOP;
            end
            SQ_STOP: begin
               if (lvl == LVL_01)      st_d = SQ_HS_A;
               else if (lvl == LVL_10) st_d = SQ_P_A;
               else                    pls_d.err = 1'b1;
            end
            SQ_HS_A: begin
               if (lvl == LVL_00) begin
                  st_d     = SQ_HS_RUN;
                  pls_d.hs = 1'b1;
               end else pls_d.err = 1'b1;
            end
            SQ_HS_RUN: begin
               if (lvl == LVL_11) st_d = SQ_STOP;
            end
            SQ_P_A: begin
               if (lvl == LVL_00) st_d = SQ_P_B;
               else               pls_d.err = 1'b1;
            end
            SQ_P_B: begin
               if (lvl == LVL_01)      st_d = SQ_ESC_C;
               else if (lvl == LVL_10) st_d = SQ_TRN_C;
               else                    pls_d.err = 1'b1;
            end
            SQ_ESC_C: begin
               if (lvl == LVL_00) begin
                  st_d      = SQ_ESC;
                  pls_d.esc = 1'b1;
               end else pls_d.err = 1'b1;
            end
            SQ_TRN_C: begin
               if (lvl == LVL_00) begin
                  st_d      = SQ_WAIT;
                  pls_d.trn = 1'b1;
               end else pls_d.err = 1'b1;
            end
            SQ_ESC: begin
               if (lvl == LVL_10) st_d = SQ_ESC_X;
            end
            SQ_ESC_X: begin
               if (lvl == LVL_11) begin
                  st_d           = SQ_STOP;
                  pls_d.esc_exit = 1'b1;
               end else st_d = SQ_ESC;
            end
            default: st_d = SQ_WAIT;
         endcase
         if (pls_d.err) st_d = (lvl == LVL_11) ? SQ_STOP : SQ_WAIT;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SQ_WAIT;
         pls_q <= '0;
      end else begin
         st_q  <= st_d;
         pls_q <= pls_d;
      end
   end

   assign pulse_o  = pls_q;
   assign stop_o   = (st_q == SQ_STOP);
   assign in_esc_o = (st_q == SQ_ESC) || (st_q == SQ_ESC_X);

endmodule

// File: rtl/lp_req_decoder.sv
module lp_req_decoder
   import lp_req_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int DWELL_CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lane_dp_i,
   input  logic lane_dn_i,
   output logic hs_req_o,
   output logic esc_req_o,
   output logic trn_req_o,
   output logic seq_err_o,
   output logic esc_exit_o,
   output logic stop_o,
   output logic in_esc_o
);

   localparam int LINES = 2;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DWELL_CYCLES < 1) begin : g_bad_dwell
      $error("DWELL_CYCLES must be at least 1");
   end

   logic [LINES-1:0] synced;
   logic [1:0]       level;
   logic             change;
   req_pulse_t       pulses;

   lp_line_sync #(
      .STAGES (SYNC_STAGES),
      .LINES  (LINES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({lane_dp_i, lane_dn_i}),
      .q_o   (synced)
   );

   lp_dwell_filter #(
      .DWELL (DWELL_CYCLES)
   ) u_filt (
      .clk      (clk),
      .rst_n    (rst_n),
      .sample_i (synced),
      .level_o  (level),
      .change_o (change)
   );

   lp_seq_fsm u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_i  (level),
      .change_i (change),
      .pulse_o  (pulses),
      .stop_o   (stop_o),
      .in_esc_o (in_esc_o)
   );

   assign hs_req_o   = pulses.hs;
   assign esc_req_o  = pulses.esc;
   assign trn_req_o  = pulses.trn;
   assign seq_err_o  = pulses.err;
   assign esc_exit_o = pulses.esc_exit;

endmodule

// File: rtl/lp_req_chk.sv
module lp_req_chk (
   input logic clk,
   input logic rst_n,
   input logic hs,
   input logic esc,
   input logic trn,
   input logic err,
   input logic esc_exit,
   input logic stop,
   input logic in_esc
);

   // R9
   pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hs, esc, trn, err, esc_exit}));

   // R9
   hs_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs |=> !hs);

   // R9
   esc_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      esc |=> !esc);

   // R9
   err_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);

   // R3
   hs_leaves_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hs |-> (!stop && !in_esc));

   // R4
   esc_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      esc |-> (in_esc && !stop));

   // R5
   trn_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trn |-> (!stop && !in_esc));

   // R6
   exit_to_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      esc_exit |-> (stop && !in_esc));

   // R4
   stop_esc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(stop && in_esc));

endmodule

bind lp_req_decoder lp_req_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hs       (hs_req_o),
   .esc      (esc_req_o),
   .trn      (trn_req_o),
   .err      (seq_err_o),
   .esc_exit (esc_exit_o),
   .stop     (stop_o),
   .in_esc   (in_esc_o)
);

// File: tb/tb_lp_req_decoder.sv
module tb_lp_req_decoder;

   localparam int DWELL = 4;
   localparam int HOLD  = 12;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [1:0] lines = 2'b00;
   logic hs, esc, trn, err, ex, stop, in_esc;

   int checks = 0;
   int errors = 0;
   int n_hs = 0, n_esc = 0, n_trn = 0, n_err = 0, n_ex = 0;
   int n_wide = 0, n_overlap = 0;
   logic [4:0] prev_p = '0;

   always #4 clk = ~clk;

   lp_req_decoder #(.SYNC_STAGES(2), .DWELL_CYCLES(DWELL)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .lane_dp_i  (lines[1]),
      .lane_dn_i  (lines[0]),
      .hs_req_o   (hs),
      .esc_req_o  (esc),
      .trn_req_o  (trn),
      .seq_err_o  (err),
      .esc_exit_o (ex),
      .stop_o     (stop),
      .in_esc_o   (in_esc)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         n_hs  += int'(hs);
         n_esc += int'(esc);
         n_trn += int'(trn);
         n_err += int'(err);
         n_ex  += int'(ex);
         if (|(prev_p & {hs, esc, trn, err, ex})) n_wide++;
         if ($countones({hs, esc, trn, err, ex}) > 1) n_overlap++;
         prev_p = {hs, esc, trn, err, ex};
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic drive(input logic [1:0] v, input int hold);
      @(negedge clk);
      lines = v;
      repeat (hold - 1) @(negedge clk);
   endtask

   int b_hs, b_esc, b_trn, b_err, b_ex;
   task automatic snap();
      b_hs = n_hs; b_esc = n_esc; b_trn = n_trn; b_err = n_err; b_ex = n_ex;
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R1 stop in reset", int'(stop), 0);
      rst_n = 1'b1;
      snap();
      repeat (HOLD) @(negedge clk);
      chk("R1 stop low on 00", int'(stop), 0);
      chk("R1 no pulse", (n_hs + n_esc + n_trn + n_err + n_ex) - (b_hs + b_esc + b_trn + b_err + b_ex), 0);

      drive(2'b11, HOLD);
      chk("R2 stop after 11", int'(stop), 1);

      // R8 short glitch below dwell
      snap();
      drive(2'b01, DWELL - 2);
      drive(2'b11, HOLD);
      chk("R8 glitch no hs", n_hs - b_hs, 0);
      chk("R8 glitch no err", n_err - b_err, 0);
      chk("R8 still stop", int'(stop), 1);

      // R3 high-speed request and quiet burst
      snap();
      drive(2'b01, HOLD);
      drive(2'b00, HOLD);
      chk("R3 hs pulse", n_hs - b_hs, 1);
      chk("R3 stop low", int'(stop), 0);
      snap();
      drive(2'b01, HOLD); drive(2'b10, HOLD); drive(2'b00, HOLD);
      chk("R3 quiet", (n_hs + n_esc + n_trn + n_err + n_ex) - (b_hs + b_esc + b_trn + b_err + b_ex), 0);
      drive(2'b11, HOLD);
      chk("R3 back to stop", int'(stop), 1);

      // R4 escape entry
      snap();
      drive(2'b10, HOLD); drive(2'b00, HOLD); drive(2'b01, HOLD); drive(2'b00, HOLD);
      chk("R4 esc pulse", n_esc - b_esc, 1);
      chk("R4 in_esc", int'(in_esc), 1);
      chk("R4 stop low", int'(stop), 0);
      // R6 payload with mark-1
      drive(2'b10, HOLD); drive(2'b00, HOLD); drive(2'b01, HOLD); drive(2'b00, HOLD);
      chk("R6 payload no exit", n_ex - b_ex, 0);
      chk("R6 still in_esc", int'(in_esc), 1);
      drive(2'b10, HOLD); drive(2'b11, HOLD);
      chk("R6 exit pulse", n_ex - b_ex, 1);
      chk("R6 stop", int'(stop), 1);
      chk("R6 in_esc low", int'(in_esc), 0);
      chk("R6 no err", n_err - b_err, 0);

      // R5 turnaround
      snap();
      drive(2'b10, HOLD); drive(2'b00, HOLD); drive(2'b10, HOLD); drive(2'b00, HOLD);
      chk("R5 trn pulse", n_trn - b_trn, 1);
      chk("R5 stop low", int'(stop), 0);
      drive(2'b11, HOLD);
      chk("R5 stop again", int'(stop), 1);
      chk("R5 no err", n_err - b_err, 0);

      // R7 sweep of every two-step path out of stop
      for (int a = 0; a < 3; a++) begin
         for (int b = 0; b < 3; b++) begin
            if (a != b) begin
               int e_hs;
               drive(2'b11, HOLD);
               snap();
               drive(2'(a), HOLD);
               drive(2'(b), HOLD);
               drive(2'b11, HOLD);
               e_hs = (a == 1 && b == 0) ? 1 : 0;
               chk($sformatf("R7 path %0d%0d hs", a, b), n_hs - b_hs, e_hs);
               chk($sformatf("R7 path %0d%0d err", a, b), n_err - b_err, 1 - e_hs);
               chk($sformatf("R7 path %0d%0d rearm", a, b), int'(stop), 1);
            end
         end
      end

      // R7 stray 11 after first escape step
      drive(2'b11, HOLD);
      snap();
      drive(2'b10, HOLD);
      drive(2'b11, HOLD);
      chk("R7 abort err", n_err - b_err, 1);
      chk("R7 abort stop", int'(stop), 1);
      chk("R7 abort no request", (n_hs + n_esc + n_trn) - (b_hs + b_esc + b_trn), 0);

      // R9 pulse shape over the whole run
      chk("R9 wide pulses", n_wide, 0);
      chk("R9 overlapping pulses", n_overlap, 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule